// File: doc/BRIEF.md
# True Dual-Port RAM with Write-Collision Tracking

The block is a word-addressed RAM with two symmetric ports, A and B. Each port has its own clock, address, write enable, write data, lane mask, address-stall input, registered read data and a read-error flag. On every rising edge of its own clock a port either writes the lanes its mask selects or only reads. In both cases the port's output register is reloaded one edge later. The other port may read or write at the same time and at an unrelated frequency.

Storage is split into one bank per port. Each bank is written only from its own clock domain. A one-bit tag per lane and word records which bank holds the newest copy. When both ports write the same lanes of the same word inside one contention window, the newest copy of those lanes is marked corrupt. The window is defined as: the other port presents a write to the same effective address at this port's edge. Any later read of the word raises the error flag until a clean write replaces every corrupt lane. Each port has a parameter that selects how its own output behaves when it reads the word it is writing on the same edge.

Top module: `tdp_ram`

## Requirements
- R1: While rst_ni is low, both read-data outputs are zero and both error flags are low.
- R2: A word written by a port is returned on that port's read data one edge after its address is presented with the write enable low.
- R3: A word written through either port is readable through the other port, and the newest write to a lane is the one returned.
- R4: Mask bit l selects data bits [8l+7:8l], with bit 0 as the least significant lane. Lanes whose mask bit is clear keep their earlier content.
- R5: When one port writes a word and the other port reads that word on the same edge, the reading port returns the content from before the write.
- R6: When both ports write overlapping lanes of the same word on the same edge, reads of that word set the error flag. Lanes written by only one of the two ports hold that port's data. Reads of other words keep the flag low.
- R7: A later write from a single port clears the error for the lanes it covers. The flag drops only when no corrupt lane remains.
- R8: With the mode RD_OLD, a writing port outputs the word as it was before its own write.
- R9: With the mode RD_NEW_MERGED, a writing port outputs its new data in selected lanes and the stored data in unselected lanes.
- R10: With the mode RD_NEW_ZERO, a writing port outputs its new data in selected lanes and zero in unselected lanes.
- R11: With the mode RD_HOLD, a writing port's output and error flag keep their previous values.
- R12: While a port's stall input is high, the port ignores its address input and reads and writes the address it last latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_a_i | input | ADDR_W | Port A word address |
| we_a_i | input | 1 | Port A write enable |
| wdata_a_i | input | DATA_W | Port A write data |
| mask_a_i | input | LANES | Port A lane select |
| stall_a_i | input | 1 | Port A address hold |
| rdata_a_o | output | DATA_W | Port A registered read data |
| err_a_o | output | 1 | Port A read of a corrupt lane |
| addr_b_i | input | ADDR_W | Port B word address |
| we_b_i | input | 1 | Port B write enable |
| wdata_b_i | input | DATA_W | Port B write data |
| mask_b_i | input | LANES | Port B lane select |
| stall_b_i | input | 1 | Port B address hold |
| rdata_b_o | output | DATA_W | Port B registered read data |
| err_b_o | output | 1 | Port B read of a corrupt lane |

## Verification
The hardest state to reach is a word that is only partly corrupt. That state needs a same-edge write from both ports with masks that overlap in some lanes and not in others. The bench drives both ports from one clock so the two writes share an edge. It then checks that the lanes written by one port alone keep clean data. Next it repairs the corrupt lanes one at a time, and the flag must stay high after the first repair and drop after the second. Two instances fed the same stimulus cover all four same-port read modes at once.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic [1:0] {
    RD_NEW_ZERO   = 2'd0,
    RD_NEW_MERGED = 2'd1,
    RD_OLD        = 2'd2,
    RD_HOLD       = 2'd3
  } rd_mode_e;
endpackage

// File: rtl/tdp_bank.sv
module tdp_bank #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter bit IS_B   = 1'b0,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [LANES-1:0]  peer_tag_i,
  input  logic [LANES-1:0]  clash_i,
  input  logic [ADDR_W-1:0] ra_i,
  input  logic [ADDR_W-1:0] rb_i,
  output logic [DATA_W-1:0] ra_data_o,
  output logic [LANES-1:0]  ra_tag_o,
  output logic [LANES-1:0]  ra_bad_o,
  output logic [DATA_W-1:0] rb_data_o,
  output logic [LANES-1:0]  rb_tag_o,
  output logic [LANES-1:0]  rb_bad_o
);
  logic [LANE_W-1:0] mem_q [DEPTH][LANES];
  logic [LANES-1:0]  tag_q [DEPTH];
  logic [LANES-1:0]  bad_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (mask_i[l]) mem_q[addr_i][l] <= data_i[l*LANE_W +: LANE_W];
      end
    end
  end

  // bank A copies peer tag (equal = A newest), bank B inverts it (differ = B newest)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < DEPTH; d++) begin
        tag_q[d] <= '0;
        bad_q[d] <= '0;
      end
    end else if (we_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (mask_i[l]) begin
          tag_q[addr_i][l] <= IS_B ? ~peer_tag_i[l] : peer_tag_i[l];
          bad_q[addr_i][l] <= clash_i[l];
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      ra_data_o[l*LANE_W +: LANE_W] = mem_q[ra_i][l];
      rb_data_o[l*LANE_W +: LANE_W] = mem_q[rb_i][l];
    end
  end

  assign ra_tag_o = tag_q[ra_i];
  assign ra_bad_o = bad_q[ra_i];
  assign rb_tag_o = tag_q[rb_i];
  assign rb_bad_o = bad_q[rb_i];

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    assert_bad_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && mask_i[g] && clash_i[g]) |=> bad_q[$past(addr_i)][g]);
    assert_bad_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && mask_i[g] && !clash_i[g]) |=> !bad_q[$past(addr_i)][g]);
  end
endmodule

// File: rtl/tdp_port.sv
module tdp_port
  import tdp_pkg::*;
#(
  parameter rd_mode_e MODE = RD_OLD,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 6,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stall_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [LANES-1:0]  clash_i,
  input  logic [DATA_W-1:0] cur_data_i,
  input  logic [LANES-1:0]  cur_bad_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [DATA_W-1:0] q_o,
  output logic              err_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] merged, zeroed, q_d;
  logic              err_d, upd;

  assign eff_addr_o = stall_i ? addr_q : addr_i;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      merged[l*LANE_W +: LANE_W] = mask_i[l] ? data_i[l*LANE_W +: LANE_W]
                                             : cur_data_i[l*LANE_W +: LANE_W];
      zeroed[l*LANE_W +: LANE_W] = mask_i[l] ? data_i[l*LANE_W +: LANE_W] : '0;
    end
  end

  always_comb begin
    upd   = 1'b1;
    q_d   = cur_data_i;
    err_d = |cur_bad_i;
    if (we_i) begin
      case (MODE)
        RD_NEW_MERGED: begin
          q_d   = merged;
          err_d = |((clash_i & mask_i) | (cur_bad_i & ~mask_i));
        end
        RD_NEW_ZERO: begin
          q_d   = zeroed;
          err_d = |(clash_i & mask_i);
        end
        RD_HOLD: upd = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      q_o    <= '0;
      err_o  <= 1'b0;
    end else begin
      addr_q <= eff_addr_o;
      if (upd) begin
        q_o   <= q_d;
        err_o <= err_d;
      end
    end
  end

  assert_stall_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> addr_q == $past(addr_q));
  assert_clean_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && cur_bad_i == '0) |=> !err_o);

  if (MODE == RD_HOLD) begin : g_hold
    assert_hold_out_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> ($stable(q_o) && $stable(err_o)));
  end
  if (MODE == RD_OLD) begin : g_old
    assert_old_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> q_o == $past(cur_data_i));
  end
endmodule

// File: rtl/tdp_ram.sv
module tdp_ram
  import tdp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 64,
  parameter rd_mode_e MODE_A = RD_OLD,
  parameter rd_mode_e MODE_B = RD_NEW_MERGED,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic              we_a_i,
  input  logic [DATA_W-1:0] wdata_a_i,
  input  logic [LANES-1:0]  mask_a_i,
  input  logic              stall_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic              err_a_o,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic              we_b_i,
  input  logic [DATA_W-1:0] wdata_b_i,
  input  logic [LANES-1:0]  mask_b_i,
  input  logic              stall_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic              err_b_o
);
  logic [ADDR_W-1:0] eff_a, eff_b;
  logic [LANES-1:0]  clash;
  logic [DATA_W-1:0] a_ra_data, a_rb_data, b_ra_data, b_rb_data, cur_a, cur_b;
  logic [LANES-1:0]  a_ra_tag, a_rb_tag, b_ra_tag, b_rb_tag;
  logic [LANES-1:0]  a_ra_bad, a_rb_bad, b_ra_bad, b_rb_bad, bad_a, bad_b;

  // contention window: other port presents a write to the same word at this edge
  assign clash = (we_a_i && we_b_i && eff_a == eff_b) ? (mask_a_i & mask_b_i) : '0;

  tdp_bank #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .IS_B(1'b0)) u_bank_a (
    .clk_i(clk_a_i), .rst_ni(rst_ni), .we_i(we_a_i), .addr_i(eff_a),
    .data_i(wdata_a_i), .mask_i(mask_a_i), .peer_tag_i(b_ra_tag), .clash_i(clash),
    .ra_i(eff_a), .rb_i(eff_b),
    .ra_data_o(a_ra_data), .ra_tag_o(a_ra_tag), .ra_bad_o(a_ra_bad),
    .rb_data_o(a_rb_data), .rb_tag_o(a_rb_tag), .rb_bad_o(a_rb_bad));

  tdp_bank #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .IS_B(1'b1)) u_bank_b (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .we_i(we_b_i), .addr_i(eff_b),
    .data_i(wdata_b_i), .mask_i(mask_b_i), .peer_tag_i(a_rb_tag), .clash_i(clash),
    .ra_i(eff_a), .rb_i(eff_b),
    .ra_data_o(b_ra_data), .ra_tag_o(b_ra_tag), .ra_bad_o(b_ra_bad),
    .rb_data_o(b_rb_data), .rb_tag_o(b_rb_tag), .rb_bad_o(b_rb_bad));

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    localparam int LO = l * LANE_W;
    assign cur_a[LO +: LANE_W] = (a_ra_tag[l] == b_ra_tag[l]) ? a_ra_data[LO +: LANE_W]
                                                               : b_ra_data[LO +: LANE_W];
    assign bad_a[l]            = (a_ra_tag[l] == b_ra_tag[l]) ? a_ra_bad[l] : b_ra_bad[l];
    assign cur_b[LO +: LANE_W] = (a_rb_tag[l] == b_rb_tag[l]) ? a_rb_data[LO +: LANE_W]
                                                               : b_rb_data[LO +: LANE_W];
    assign bad_b[l]            = (a_rb_tag[l] == b_rb_tag[l]) ? a_rb_bad[l] : b_rb_bad[l];
  end

  tdp_port #(.MODE(MODE_A), .LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_port_a (
    .clk_i(clk_a_i), .rst_ni(rst_ni), .addr_i(addr_a_i), .stall_i(stall_a_i),
    .we_i(we_a_i), .data_i(wdata_a_i), .mask_i(mask_a_i), .clash_i(clash),
    .cur_data_i(cur_a), .cur_bad_i(bad_a), .eff_addr_o(eff_a),
    .q_o(rdata_a_o), .err_o(err_a_o));

  tdp_port #(.MODE(MODE_B), .LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_port_b (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .addr_i(addr_b_i), .stall_i(stall_b_i),
    .we_i(we_b_i), .data_i(wdata_b_i), .mask_i(mask_b_i), .clash_i(clash),
    .cur_data_i(cur_b), .cur_bad_i(bad_b), .eff_addr_o(eff_b),
    .q_o(rdata_b_o), .err_o(err_b_o));
endmodule

// File: tb/tdp_ram_bench.sv
`timescale 1ns/1ps
module tdp_ram_bench;
  import tdp_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0]  addr_a = '0, addr_b = '0;
  logic        we_a = 1'b0, we_b = 1'b0, st_a = 1'b0, st_b = 1'b0;
  logic [31:0] wd_a = '0, wd_b = '0;
  logic [3:0]  mk_a = '0, mk_b = '0;
  logic [31:0] q_a, q_b, q2_a, q2_b;
  logic        e_a, e_b, e2_a, e2_b;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  tdp_ram #(.MODE_A(RD_OLD), .MODE_B(RD_NEW_MERGED)) u_tdp_ram (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_n),
    .addr_a_i(addr_a), .we_a_i(we_a), .wdata_a_i(wd_a), .mask_a_i(mk_a), .stall_a_i(st_a),
    .rdata_a_o(q_a), .err_a_o(e_a),
    .addr_b_i(addr_b), .we_b_i(we_b), .wdata_b_i(wd_b), .mask_b_i(mk_b), .stall_b_i(st_b),
    .rdata_b_o(q_b), .err_b_o(e_b));

  tdp_ram #(.MODE_A(RD_NEW_ZERO), .MODE_B(RD_HOLD)) u_tdp_ram_alt (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_n),
    .addr_a_i(addr_a), .we_a_i(we_a), .wdata_a_i(wd_a), .mask_a_i(mk_a), .stall_a_i(st_a),
    .rdata_a_o(q2_a), .err_a_o(e2_a),
    .addr_b_i(addr_b), .we_b_i(we_b), .wdata_b_i(wd_b), .mask_b_i(mk_b), .stall_b_i(st_b),
    .rdata_b_o(q2_b), .err_b_o(e2_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic port_a(input logic we, input logic [5:0] ad, input logic [31:0] d,
                        input logic [3:0] m);
    we_a = we; addr_a = ad; wd_a = d; mk_a = m;
  endtask

  task automatic port_b(input logic we, input logic [5:0] ad, input logic [31:0] d,
                        input logic [3:0] m);
    we_b = we; addr_b = ad; wd_b = d; mk_b = m;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    step();
    chk("R1 q_a", q_a, 32'h0);
    chk("R1 q_b", q_b, 32'h0);
    chk("R1 err", {30'd0, e_a, e_b}, 32'h0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_basic();
    port_a(1, 6'd5, 32'h1122_3344, 4'hF); port_b(0, 6'd0, '0, '0); step();
    port_a(0, 6'd5, '0, '0); port_b(0, 6'd5, '0, '0); step();
    chk("R2 own read", q_a, 32'h1122_3344);
    chk("R3 cross read", q_b, 32'h1122_3344);
    chk("R2 err", {31'd0, e_a}, 32'h0);
    port_b(1, 6'd5, 32'hAABB_CCDD, 4'hF); step();
    chk("R5 read during peer write", q_a, 32'h1122_3344);
    port_b(0, 6'd5, '0, '0); step();
    chk("R3 newest wins", q_a, 32'hAABB_CCDD);
  endtask

  task automatic t_mask();
    port_a(1, 6'd7, 32'h0102_0304, 4'hF); step();
    port_a(1, 6'd7, 32'hFFFF_FFFF, 4'b0101); step();
    port_a(0, 6'd7, '0, '0); step();
    chk("R4 lane mask", q_a, 32'h01FF_03FF);
  endtask

  task automatic t_rdw();
    port_a(1, 6'd9, 32'h1020_3040, 4'hF); port_b(0, 6'd9, '0, '0); step();
    port_a(0, 6'd9, '0, '0); step();
    chk("R2 setup", q2_b, 32'h1020_3040);
    port_a(1, 6'd9, 32'hAAAA_AAAA, 4'b0011); step();
    chk("R8 old data", q_a, 32'h1020_3040);
    chk("R10 zero masked", q2_a, 32'h0000_AAAA);
    chk("R5 peer old", q_b, 32'h1020_3040);
    port_a(0, 6'd9, '0, '0); port_b(1, 6'd9, 32'h5555_5555, 4'b1100); step();
    chk("R9 merged", q_b, 32'h5555_AAAA);
    chk("R11 hold", q2_b, 32'h1020_3040);
    chk("R5 peer old b", q_a, 32'h1020_AAAA);
    port_b(0, 6'd9, '0, '0); step();
    chk("R3 final", q_a, 32'h5555_AAAA);
  endtask

  task automatic t_collide();
    port_a(1, 6'd12, 32'h1111_1111, 4'b0111); port_b(1, 6'd12, 32'h2222_2222, 4'b1110); step();
    port_a(0, 6'd12, '0, '0); port_b(0, 6'd12, '0, '0); step();
    chk("R6 err a", {31'd0, e_a}, 32'h1);
    chk("R6 err b", {31'd0, e_b}, 32'h1);
    chk("R6 lone lane a", {24'd0, q_a[7:0]}, 32'h11);
    chk("R6 lone lane b", {24'd0, q_a[31:24]}, 32'h22);
    port_a(0, 6'd5, '0, '0); step();
    chk("R6 other word clean", {31'd0, e_a}, 32'h0);
    port_a(1, 6'd12, 32'h3333_3333, 4'b0010); step();
    port_a(0, 6'd12, '0, '0); step();
    chk("R7 partial repair", {31'd0, e_a}, 32'h1);
    port_a(1, 6'd12, 32'h3333_3333, 4'b0100); step();
    port_a(0, 6'd12, '0, '0); step();
    chk("R7 repaired err", {31'd0, e_a}, 32'h0);
    chk("R7 repaired data", q_a, 32'h2233_3311);
  endtask

  task automatic t_stall();
    port_a(0, 6'd5, '0, '0); step();
    st_a = 1'b1; port_a(0, 6'd9, '0, '0); step();
    chk("R12 stalled read", q_a, 32'hAABB_CCDD);
    port_a(1, 6'd20, 32'h7777_7777, 4'hF); step();
    st_a = 1'b0; port_a(0, 6'd5, '0, '0); step();
    chk("R12 stalled write", q_a, 32'h7777_7777);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_mask();
    t_rdw();
    t_collide();
    t_stall();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule